// File: doc/BRIEF.md
# Two-Stage Serial Clock Rate Generator

This block derives the timing for an I2C master's serial clock from the system clock. Two small divisor fields are cascaded. A 2-bit prescaler counts system cycles. A 6-bit divider advances only when the prescaler wraps. Their product sets the spacing of a one-cycle enable pulse, `tick`. A bit engine uses `tick` to step its SCL and SDA phases, and there are 22 ticks in every serial clock period. The resulting serial clock rate is Fclk / (22 × (A+1) × (B+1)). The fastest rate is Fclk / 22, with both fields at zero.

The block also keeps a phase counter that runs through 22 steps on ticks. That counter drives a free-running square wave, `scl`, for observation. The wave is low for the first half of each period and high for the second half. While `en` is low, every counter is held cleared, no ticks appear and `scl` rests high. Software may only change the divisor fields while `en` is low.

Top module: `scl_rate_gen`

## Requirements
- R1: While `en` is high, `tick` pulses once every (A+1)×(B+1) clock cycles. The first pulse falls in the (A+1)×(B+1)-th enabled cycle, counting the first cycle with `en` high as cycle 1.
- R2: With `div_a` = 0 and `div_b` = 0, `tick` is high in every enabled cycle, so the serial clock runs at Fclk / 22.
- R3: With `div_a` = 3 and `div_b` = 63, ticks are 256 cycles apart, and one `scl` period lasts 5632 cycles.
- R4: Counting tick intervals from the moment `en` rises, `scl` is low during intervals 0 to 10 and high during intervals 11 to 21. The pattern then repeats every 22 intervals, giving a 50% duty cycle.
- R5: In any cycle where `en` is low, `tick` is 0 and `scl` is 1. This also holds after reset. When `en` goes high again, the sequence restarts from the beginning as described in R1 and R4.
- R6: When (A+1)×(B+1) > 1, `tick` never stays high for two consecutive cycles.
- R7: While enabled, `scl` changes level only in the cycle right after a tick. The 6-bit stage only advances in cycles where the 2-bit stage wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears all counters |
| div_a | input | 2 | Prescaler divisor A (ratio A+1) |
| div_b | input | 6 | Second-stage divisor B (ratio B+1) |
| tick | output | 1 | One-cycle enable, 22 per serial clock period |
| scl | output | 1 | Observation square wave at the serial clock rate |

## Verification
A prescaler that wraps at the wrong count shifts every tick. The cycle-by-cycle tick comparison therefore flags it within one tick period, at most 256 cycles. A second-stage or phase counter that skips or repeats a state moves the `scl` edges. This shows up no later than the next half period, within 11 tick intervals. A clear that fails when `en` drops shows up in the first idle cycle as a stray tick or a low `scl`. If the clear fails to restart the counters, the first tick after re-enabling arrives too early, and the bench reports that.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned PHASES_PER_SCL = 22;
  localparam int unsigned LOW_PHASES     = PHASES_PER_SCL / 2;
  localparam int unsigned PHASE_W        = $clog2(PHASES_PER_SCL);

  typedef logic [PHASE_W-1:0] phase_t;

  // Serial clock level for a given phase: low half first, then high half.
  function automatic logic scl_from_phase(input phase_t ph);
    return ph >= phase_t'(LOW_PHASES);
  endfunction

  // Last phase value before the counter wraps.
  function automatic phase_t last_phase();
    return phase_t'(PHASES_PER_SCL - 1);
  endfunction
endpackage

// File: rtl/scl_wrap_counter.sv
module scl_wrap_counter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] count;

  // Wrap at or beyond the limit so a lowered limit can never trap the count.
  function automatic logic at_limit(input logic [W-1:0] c, input logic [W-1:0] l);
    return c >= l;
  endfunction

  assign wrap = adv & at_limit(count, lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (wrap)   count <= '0;
    else if (adv)    count <= count + 1'b1;
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   adv,
  output phase_t phase,
  output logic   scl
);
  logic phase_end;

  assign phase_end = (phase == last_phase());

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= '0;
    else if (clr)            phase <= '0;
    else if (adv)            phase <= phase_end ? '0 : phase + 1'b1;
  end

  // Idle holds the line released (high).
  assign scl = clr | scl_from_phase(phase);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_div_pkg::*;
#(
  parameter int A_W = 2,
  parameter int B_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [A_W-1:0] div_a,
  input  logic [B_W-1:0] div_b,
  output logic           tick,
  output logic           scl
);
  logic stop;
  logic stage_a_wrap;
  logic stage_b_wrap;

  assign stop = ~en;

  scl_wrap_counter #(.W(A_W)) u_stage_a (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (stop),
    .adv  (en),
    .lim  (div_a),
    .wrap (stage_a_wrap)
  );

  scl_wrap_counter #(.W(B_W)) u_stage_b (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (stop),
    .adv  (stage_a_wrap),
    .lim  (div_b),
    .wrap (stage_b_wrap)
  );

  assign tick = stage_b_wrap;

  phase_t phase_unused_name;
  scl_phase_gen u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (stop),
    .adv  (tick),
    .phase(phase_unused_name),
    .scl  (scl)
  );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
  import scl_div_pkg::*;
#(
  parameter int A_W = 2,
  parameter int B_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [A_W-1:0] div_a,
  input logic [B_W-1:0] div_b,
  input logic           tick,
  input logic           scl,
  input logic           stage_a_wrap,
  input phase_t         phase
);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!tick && scl));

  a_r2_fastest_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div_a == '0 && div_b == '0) |-> tick);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_a != '0 || div_b != '0)) |=>
      (!tick || !$stable(div_a) || !$stable(div_b)));

  a_r7_scl_moves_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (scl != $past(scl))) |-> $past(tick));

  a_r7_b_needs_a_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en) |-> 1'b0);

  a_r1_tick_needs_a_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> stage_a_wrap);

  a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= last_phase());
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .div_a       (div_a),
  .div_b       (div_b),
  .tick        (tick),
  .scl         (scl),
  .stage_a_wrap(stage_a_wrap),
  .phase       (phase_unused_name)
);

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] div_a = '0;
  logic [5:0] div_b = '0;
  logic       tick;
  logic       scl;

  int  n_checks = 0;
  int  n_fail = 0;
  int  k = 0;
  bit  done = 1'b0;
  logic prev_tick = 1'b0;
  logic prev_scl = 1'b1;

  always #10 clk = ~clk;

  scl_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .div_a(div_a), .div_b(div_b), .tick(tick), .scl(scl)
  );

  function automatic int period(input int a, input int b);
    return (a + 1) * (b + 1);
  endfunction

  function automatic bit exp_tick(input int kk, input int p);
    return (kk % p) == (p - 1);
  endfunction

  function automatic bit exp_scl(input int kk, input int p);
    return ((kk / p) % 22) >= 11;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (A=%0d B=%0d k=%0d)",
               tag, act, exp, div_a, div_b, k);
    end
  endtask

  // Called at a negedge after inputs are driven.
  task automatic step(input string ttag);
    int p;
    #1;
    p = period(int'(div_a), int'(div_b));
    if (en) begin
      check(ttag, tick, exp_tick(k, p));
      check("R4 scl level", scl, exp_scl(k, p));
      if (p > 1 && prev_tick === 1'b1) check("R6 single pulse", tick, 1'b0);
      if (k > 0 && scl !== prev_scl) check("R7 scl edge after tick", prev_tick, 1'b1);
    end else begin
      check("R5 idle tick", tick, 1'b0);
      check("R5 idle scl", scl, 1'b1);
    end
    prev_tick = tick;
    prev_scl  = scl;
    @(posedge clk);
    if (en) k++;
    else    k = 0;
    @(negedge clk);
  endtask

  task automatic run(input int a, input int b, input int n, input string tag);
    div_a = 2'(a);
    div_b = 6'(b);
    en = 1'b1;
    repeat (n) step(tag);
  endtask

  task automatic idle(input int n);
    en = 1'b0;
    repeat (n) step("R5");
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R5 reset tick", tick, 1'b0);
    check("R5 reset scl", scl, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    idle(2);
    run(0, 0, 70, "R2 fastest tick");
    idle(3);
    run(1, 2, 150, "R1 tick period");
    idle(2);
    run(1, 2, 40, "R5 restart after enable");
    idle(1);
    run(3, 63, 256 * 22 + 20, "R3 slowest tick");
    idle(1);
    run(2, 0, 80, "R1 prescaler only");
    idle(1);
    run(0, 5, 150, "R1 second stage only");
    for (int i = 0; i < 25; i++) begin
      int a;
      int b;
      int n;
      a = int'($urandom_range(3, 0));
      b = int'($urandom_range(63, 0));
      n = period(a, b) * 23 + 3;
      if (n > 1500) n = 1500;
      idle(int'($urandom_range(3, 1)));
      run(a, b, n, "R1 random divisors");
    end
    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule